// File: doc/BRIEF.md
# Programmable Video Sync Generator

This block produces horizontal and vertical sync pulses for a video bus when the device owns the timing (master mode). It runs from the double-rate pixel clock. A qualifier input marks which of each pair of edges counts as a pixel clock, and a polarity input chooses whether the high or the low level of the qualifier is the valid one. A pixel counter and a line counter trace the raster. The pulses are decoded from the two counters and registered before they leave the block.

Software programs the raster size: pixel clocks per line and lines per frame. It also programs the line where vertical sync ends and the pixel where horizontal sync starts, plus the width of the horizontal pulse. Two polarity bits choose active-high or active-low output for each sync. These are the same bits the capture side uses to pick its counting edge. When master mode is off, the output enable drops, both outputs sit at their inactive level and both counters are held at zero. Re-entering master mode therefore always starts a fresh frame at pixel 0, line 0.

Top module: `sync_master_gen`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `sync_oe` is 0 and each sync output is at its inactive level: the value of its polarity bit.
- R2: `sync_oe` equals the value `master_en` had at the previous rising clock edge.
- R3: The pixel counter advances only on rising edges where `pix_qual` equals `qual_pol`. On all other edges the raster position, and so the sync pattern, does not move.
- R4: The pixel counter wraps from `line_total-1` to 0, and at that wrap the line counter increments. The line counter wraps from `frame_total-1` to 0. The default 10-bit fields hold a 858-clock line and a 525-line frame.
- R5: Horizontal sync is active on the `hs_width` pixel positions that start at `hs_start` and continue modulo `line_total`, on every line. A width of 0 never asserts it.
- R6: Vertical sync is active on lines 0 through `vs_lines-1`. Its edges therefore coincide with the pixel counter wrap.
- R7: When a polarity bit (`hs_low_active` or `vs_low_active`) is 1, the sync is active low and idles high. When it is 0, the sync is active high.
- R8: When `master_en` is low, both counters are cleared, and the next sample shows both syncs inactive. After re-enabling, the raster restarts at pixel 0, line 0.
- R9: Each output reflects the counter state from one rising edge earlier (one register stage after the counters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Sync master mode enable |
| pix_qual | input | 1 | Pixel-edge qualifier (half-rate clock level) |
| qual_pol | input | 1 | Qualifier level that marks a valid edge |
| line_total | input | PIX_W | Pixel clocks per line |
| frame_total | input | LINE_W | Lines per frame |
| vs_lines | input | LINE_W | Vertical sync length in lines |
| hs_start | input | PIX_W | Pixel position where horizontal sync begins |
| hs_width | input | PIX_W | Horizontal sync width in pixel clocks |
| hs_low_active | input | 1 | 1: horizontal sync active low |
| vs_low_active | input | 1 | 1: vertical sync active low |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| sync_oe | output | 1 | Output enable for both syncs |

## Verification
The bench builds the generator with its default 10-bit pixel and line fields, so every programmed size up to 1023 is reachable. It uses small rasters (12 by 6, 16 by 525, 858 by 4) so that whole frames, and the line and frame wraps, fit in a short run while the 858-clock line and the 525-line frame are still exercised. Horizontal pulses that straddle the line end, zero width, both polarities, both qualifier senses and a mid-frame drop of master mode are each reached through the programming inputs alone.

// File: rtl/sgen_pkg.sv
package sgen_pkg;
  // One bit per sync channel: index 0 horizontal, index 1 vertical
  localparam int NUM_CH = 2;
  localparam int CH_HS  = 0;
  localparam int CH_VS  = 1;

  typedef logic [NUM_CH-1:0] sync_vec_t;
endpackage

// File: rtl/sgen_qual.sv
module sgen_qual (
  input  logic master_en,
  input  logic pix_qual,
  input  logic qual_pol,
  output logic pix_ce
);
  // A pixel edge is valid when the qualifier sits at the chosen level
  always_comb pix_ce = master_en & (pix_qual ~^ qual_pol);
endmodule

// File: rtl/sgen_counters.sv
module sgen_counters #(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pix_ce,
  input  logic [PIX_W-1:0]  line_total,
  input  logic [LINE_W-1:0] frame_total,
  output logic [PIX_W-1:0]  pix,
  output logic [LINE_W-1:0] line
);
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic pix_last;
  logic line_last;

  always_comb begin
    pix_last  = (pix  >= line_total  - PIX_ONE);
    line_last = (line >= frame_total - LINE_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pix  <= '0;
      line <= '0;
    end else if (pix_ce) begin
      if (pix_last) begin
        pix  <= '0;
        line <= line_last ? '0 : line + LINE_ONE;
      end else begin
        pix  <= pix + PIX_ONE;
      end
    end
  end
endmodule

// File: rtl/sgen_decode.sv
module sgen_decode
  import sgen_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input  logic [PIX_W-1:0]  pix,
  input  logic [LINE_W-1:0] line,
  input  logic [PIX_W-1:0]  line_total,
  input  logic [PIX_W-1:0]  hs_start,
  input  logic [PIX_W-1:0]  hs_width,
  input  logic [LINE_W-1:0] vs_lines,
  output sync_vec_t         active
);
  localparam int DW = PIX_W + 1;

  logic [DW-1:0] pix_x, start_x, total_x, offset;

  always_comb begin
    pix_x   = {1'b0, pix};
    start_x = {1'b0, hs_start};
    total_x = {1'b0, line_total};
    // Distance from the pulse start, measured forward around the line
    if (pix_x >= start_x) offset = pix_x - start_x;
    else                  offset = pix_x + total_x - start_x;
    active         = '0;
    active[CH_HS]  = (offset < {1'b0, hs_width});
    active[CH_VS]  = (line < vs_lines);
  end
endmodule

// File: rtl/sync_master_gen.sv
module sync_master_gen
  import sgen_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_en,
  input  logic              pix_qual,
  input  logic              qual_pol,
  input  logic [PIX_W-1:0]  line_total,
  input  logic [LINE_W-1:0] frame_total,
  input  logic [LINE_W-1:0] vs_lines,
  input  logic [PIX_W-1:0]  hs_start,
  input  logic [PIX_W-1:0]  hs_width,
  input  logic              hs_low_active,
  input  logic              vs_low_active,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              sync_oe
);
  logic              pix_ce;
  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_cnt;
  sync_vec_t         act;
  sync_vec_t         pol;
  sync_vec_t         sync_q;
  logic              oe_q;

  sgen_qual u_qual (
    .master_en (master_en),
    .pix_qual  (pix_qual),
    .qual_pol  (qual_pol),
    .pix_ce    (pix_ce)
  );

  sgen_counters #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .run         (master_en),
    .pix_ce      (pix_ce),
    .line_total  (line_total),
    .frame_total (frame_total),
    .pix         (pix_cnt),
    .line        (line_cnt)
  );

  sgen_decode #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_dec (
    .pix        (pix_cnt),
    .line       (line_cnt),
    .line_total (line_total),
    .hs_start   (hs_start),
    .hs_width   (hs_width),
    .vs_lines   (vs_lines),
    .active     (act)
  );

  always_comb begin
    pol        = '0;
    pol[CH_HS] = hs_low_active;
    pol[CH_VS] = vs_low_active;
  end

  // One output register per channel; idle level equals the polarity bit
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst || !master_en) sync_q[ch] <= pol[ch];
      else                   sync_q[ch] <= act[ch] ^ pol[ch];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= master_en;
  end

  assign hsync_o = sync_q[CH_HS];
  assign vsync_o = sync_q[CH_VS];
  assign sync_oe = oe_q;
endmodule

// File: rtl/sync_master_gen_chk.sv
module sync_master_gen_chk #(
  parameter int PIX_W  = 10,
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              master_en,
  input logic              pix_qual,
  input logic              qual_pol,
  input logic [PIX_W-1:0]  line_total,
  input logic              hs_low_active,
  input logic              vs_low_active,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic              sync_oe,
  input logic [PIX_W-1:0]  pix_cnt,
  input logic [LINE_W-1:0] line_cnt
);
  // R2
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    master_en |=> sync_oe);

  // R2
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> !sync_oe);

  // R8
  cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (pix_cnt == '0 && line_cnt == '0));

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !master_en |=> (hsync_o == $past(hs_low_active) && vsync_o == $past(vs_low_active)));

  // R3
  qual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && (pix_qual != qual_pol)) |=> ($stable(pix_cnt) && $stable(line_cnt)));

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (master_en && (pix_cnt < line_total - PIX_W'(1))) |=> $stable(line_cnt));
endmodule

bind sync_master_gen sync_master_gen_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .master_en     (master_en),
  .pix_qual      (pix_qual),
  .qual_pol      (qual_pol),
  .line_total    (line_total),
  .hs_low_active (hs_low_active),
  .vs_low_active (vs_low_active),
  .hsync_o       (hsync_o),
  .vsync_o       (vsync_o),
  .sync_oe       (sync_oe),
  .pix_cnt       (pix_cnt),
  .line_cnt      (line_cnt)
);

// File: tb/sim_sync_master_gen.sv
module sim_sync_master_gen;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 10;
  localparam int LW = 10;

  typedef struct packed { logic oe; logic hs; logic vs; } exp_t;

  logic          clk = 0;
  logic          rst = 1;
  logic          master_en = 0;
  logic          pix_qual = 0;
  logic          qual_pol = 1;
  logic [PW-1:0] line_total = 12;
  logic [LW-1:0] frame_total = 6;
  logic [LW-1:0] vs_lines = 2;
  logic [PW-1:0] hs_start = 3;
  logic [PW-1:0] hs_width = 4;
  logic          hs_low_active = 0;
  logic          vs_low_active = 0;
  logic          hsync_o, vsync_o, sync_oe;

  int checks = 0;
  int errors = 0;
  int qual_mode = 0;          // 0 toggle, 1 hold at qual_pol, 2 hold opposite
  string phase_req = "R1";
  exp_t q[$];
  int mp = 0;
  int ml = 0;
  exp_t e;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_master_gen #(.PIX_W(PW), .LINE_W(LW)) u0 (
    .clk(clk), .rst(rst), .master_en(master_en), .pix_qual(pix_qual),
    .qual_pol(qual_pol), .line_total(line_total), .frame_total(frame_total),
    .vs_lines(vs_lines), .hs_start(hs_start), .hs_width(hs_width),
    .hs_low_active(hs_low_active), .vs_low_active(vs_low_active),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .sync_oe(sync_oe)
  );

  function automatic logic hs_exp(int p);
    int s = int'(hs_start);
    int w = int'(hs_width);
    int l = int'(line_total);
    if (w == 0) return 1'b0;
    if (s + w <= l) return (p >= s && p < s + w);
    return (p >= s || p < s + w - l);
  endfunction

  // Driver/model: predicts the sample seen after this edge (R9 latency)
  always @(posedge clk) begin
    if (rst) begin
      e.oe = 0; e.hs = hs_low_active; e.vs = vs_low_active;
      mp = 0; ml = 0;
    end else begin
      e.oe = master_en;
      if (master_en) begin
        e.hs = hs_exp(mp) ^ hs_low_active;
        e.vs = (ml < int'(vs_lines)) ^ vs_low_active;
        if (pix_qual == qual_pol) begin
          if (mp >= int'(line_total) - 1) begin
            mp = 0;
            ml = (ml >= int'(frame_total) - 1) ? 0 : ml + 1;
          end else mp = mp + 1;
        end
      end else begin
        e.hs = hs_low_active; e.vs = vs_low_active;
        mp = 0; ml = 0;
      end
    end
    q.push_back(e);
  end

  // Monitor: compares away from the active edge
  always @(negedge clk) begin
    exp_t x;
    if (q.size() > 0) begin
      x = q.pop_front();
      checks++;
      if (x.oe !== sync_oe || x.hs !== hsync_o || x.vs !== vsync_o) begin
        errors++;
        $display("FAIL %s (oe R2, hs R5, vs R6): got oe=%b hs=%b vs=%b exp oe=%b hs=%b vs=%b at %0t",
                 phase_req, sync_oe, hsync_o, vsync_o, x.oe, x.hs, x.vs, $time);
      end
    end
  end

  // Qualifier drive
  always @(posedge clk) begin
    #2;
    case (qual_mode)
      0: pix_qual = ~pix_qual;
      1: pix_qual = qual_pol;
      default: pix_qual = ~qual_pol;
    endcase
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic cfg(int l, int f, int vl, int hs, int hw, logic hp, logic vp);
    master_en = 0;
    run(2);
    line_total = PW'(l); frame_total = LW'(f); vs_lines = LW'(vl);
    hs_start = PW'(hs); hs_width = PW'(hw);
    hs_low_active = hp; vs_low_active = vp;
    run(2);
    master_en = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    run(4);
    #1;
    checks++;
    if (sync_oe !== 0 || hsync_o !== 0 || vsync_o !== 0) begin
      errors++;
      $display("FAIL R1: got oe=%b hs=%b vs=%b expected 0 0 0", sync_oe, hsync_o, vsync_o);
    end
    rst = 0;
    run(3);

    // R4 R5 R6: small raster, toggled qualifier, active high
    phase_req = "R4";
    cfg(12, 6, 2, 3, 4, 0, 0);
    run(2 * 12 * 6 * 2 + 5);

    // R5 R7: pulse straddling line end, active low
    phase_req = "R7";
    cfg(12, 6, 3, 10, 4, 1, 1);
    run(2 * 12 * 6 * 2);

    // R3: opposite qualifier sense, then qualifier held invalid
    phase_req = "R3";
    qual_pol = 0;
    cfg(12, 6, 1, 0, 2, 0, 1);
    run(200);
    qual_mode = 2;
    run(40);
    qual_mode = 0;
    run(40);

    // R8: drop master mid-frame and re-enter
    phase_req = "R8";
    qual_pol = 1;
    run(37);
    master_en = 0;
    run(3);
    master_en = 1;
    run(150);

    // R5: zero width never asserts
    phase_req = "R5";
    cfg(12, 6, 2, 5, 0, 0, 0);
    run(200);

    // R6 R4: 525-line frame with every edge valid
    phase_req = "R6";
    qual_mode = 1;
    cfg(16, 525, 6, 2, 3, 0, 1);
    run(16 * 525 + 40);

    // R4: 858-clock line
    phase_req = "R4";
    cfg(858, 4, 1, 800, 64, 1, 0);
    run(858 * 4 + 900);

    // R9 R2: latency and enable around a final toggle
    phase_req = "R9";
    qual_mode = 0;
    cfg(12, 6, 2, 0, 1, 0, 0);
    run(60);
    master_en = 0;
    run(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule